// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a bank of general-purpose input pins arranged in three groups and reports, per group, that some selected pin has toggled since the flag was last cleared. Every pin passes through a synchroniser. Its synchronised level is then compared with the level it had one cycle earlier. When a pin whose mask bit is one changes level in either direction, the sticky flag of its group is set.

A byte-wide register bus reads and writes a control register (one enable per group), a flag register (one sticky flag per group) and three mask registers (one bit per pin). A group raises its interrupt request only while its flag, its enable and the global interrupt-enable input are all one. The flag is cleared by a one-cycle acknowledge pulse when the interrupt is serviced, or by writing a one to its bit. A new change in the same cycle wins over a clear. A flag also sets while its group is disabled, so software can poll for changes.

The pin vector is 24 bits wide. Group 0 owns pins 0 to 7, group 1 owns pins 8 to 14, and group 2 owns pins 16 to 23. Pin 15 has no mask bit and never affects any flag.

Top module: `pcint_ctrl`

## Requirements
- R1: After reset the control, flag and all three mask registers read 0x00 and all interrupt requests are low.
- R2: The control register at address 0x68 holds the enable of group g in bit g (g = 0..2). Bits 7 to 3 always read zero and ignore writes.
- R3: The flag register at address 0x3B holds the flag of group g in bit g. Bits 7 to 3 always read zero. Any address that is not a register reads 0x00.
- R4: The mask registers sit at 0x6B, 0x6C and 0x6D for groups 0, 1 and 2. Bit i of the register for group g selects pin 8g+i. Bit 7 at 0x6C reads zero and ignores writes, so pin 15 never sets a flag.
- R5: A rising or a falling level change on a pin whose mask bit is one sets its group's flag. If the pin changes before clock edge k, the flag reads one after edge k+2: two synchroniser stages, then the flag register.
- R6: A level change on a pin whose mask bit is zero leaves every flag unchanged.
- R7: A flag is set by a qualifying change whether or not its group's enable bit is one.
- R8: The interrupt request of group g equals flag g AND enable g AND the global interrupt-enable input.
- R9: A one-cycle pulse on the acknowledge bit of group g clears flag g at the next clock edge.
- R10: Writing 0x3B with a one in bit g clears flag g. A zero in bit g leaves flag g unchanged.
- R11: When a qualifying change and a clear (acknowledge or write-one) reach the same group in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pins_i | input | 24 | Asynchronous pin levels, bit 8g+i is pin i of group g |
| bus_addr_i | input | 8 | Register address |
| bus_we_i | input | 1 | Write strobe for the current address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the register at bus_addr_i (combinational) |
| ack_i | input | 3 | Per-group service acknowledge pulse |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
The bench builds the block with its default parameters: three groups, the 0xFF7FFF pin-presence pattern that removes pin 15, a two-stage synchroniser and the 0x68, 0x3B and 0x6B register addresses. With these values a single run reaches the uneven group sizes, including the reserved mask bit and the pin that has no mask bit. It also reaches the exact three-edge delay from a pin change to a visible flag, and the case where a change and a clear hit the same cycle. A behavioural model holds a queue of sampled pin vectors and the register contents, and it is compared against the read data and the request outputs on every clock.

// File: rtl/pcint_pkg.sv
package pcint_pkg;

   localparam int REG_W  = 8;
   localparam int GRP_W  = 8;
   localparam int MAX_GRP = 8;

   typedef logic [REG_W-1:0] reg_byte_t;

   // zero-extend a group vector into a bus byte
   function automatic reg_byte_t widen_to_byte(input logic [MAX_GRP-1:0] v, input int n);
      reg_byte_t r;
      r = '0;
      for (int i = 0; i < MAX_GRP; i++) begin
         if (i < n) r[i] = v[i];
      end
      return r;
   endfunction

endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
   parameter int WIDTH  = 24,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pcint_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pcint_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pcint_group.sv
module pcint_group
   import pcint_pkg::*;
#(
   parameter logic [GRP_W-1:0] PRESENT = 8'hFF
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [GRP_W-1:0] lvl_i,
   input  logic             mask_we_i,
   input  logic [GRP_W-1:0] mask_wdata_i,
   input  logic             clr_i,
   output logic [GRP_W-1:0] mask_o,
   output logic             chg_o,
   output logic             flag_o
);

   logic [GRP_W-1:0] prev_q;
   logic [GRP_W-1:0] mask_q;
   logic             flag_q;
   logic [GRP_W-1:0] toggled;

   if (PRESENT == '0) begin : g_empty_group
      $error("pcint_group: a group needs at least one present pin");
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= lvl_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)        mask_q <= '0;
      else if (mask_we_i) mask_q <= mask_wdata_i & PRESENT;
   end

   assign toggled = (lvl_i ^ prev_q) & mask_q;
   assign chg_o   = |toggled;

   // a new change takes priority over any clear
   always_ff @(posedge clk_i) begin
      if (!rst_ni)    flag_q <= 1'b0;
      else if (chg_o) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign mask_o = mask_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/pcint_ctrl.sv
module pcint_ctrl
   import pcint_pkg::*;
#(
   parameter int                    NUM_GRP        = 3,
   parameter logic [NUM_GRP*8-1:0]  PIN_PRESENT    = 24'hFF7FFF,
   parameter int                    SYNC_STAGES    = 2,
   parameter int                    ADDR_W         = 8,
   parameter logic [ADDR_W-1:0]     ADDR_CTRL      = 8'h68,
   parameter logic [ADDR_W-1:0]     ADDR_FLAG      = 8'h3B,
   parameter logic [ADDR_W-1:0]     ADDR_MASK_BASE = 8'h6B
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_GRP*8-1:0]   pins_i,
   input  logic [ADDR_W-1:0]      bus_addr_i,
   input  logic                   bus_we_i,
   input  logic [7:0]             bus_wdata_i,
   output logic [7:0]             bus_rdata_o,
   input  logic [NUM_GRP-1:0]     ack_i,
   input  logic                   gie_i,
   output logic [NUM_GRP-1:0]     irq_o
);

   localparam int PIN_W = NUM_GRP * GRP_W;

   if (NUM_GRP < 1 || NUM_GRP > MAX_GRP) begin : g_bad_grp
      $error("pcint_ctrl: NUM_GRP must be 1..8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("pcint_ctrl: ADDR_W must be positive");
   end

   logic [PIN_W-1:0]   pins_sync;
   logic [NUM_GRP-1:0] en_q;
   logic [NUM_GRP-1:0] grp_flag;
   logic [NUM_GRP-1:0] grp_chg;
   logic [NUM_GRP-1:0] grp_clr;
   logic [GRP_W-1:0]   grp_mask [NUM_GRP];
   logic               wr_ctrl;
   logic               wr_flag;

   pcint_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (pins_i),
      .sync_o  (pins_sync)
   );

   assign wr_ctrl = bus_we_i && (bus_addr_i == ADDR_CTRL);
   assign wr_flag = bus_we_i && (bus_addr_i == ADDR_FLAG);

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      en_q <= '0;
      else if (wr_ctrl) en_q <= bus_wdata_i[NUM_GRP-1:0];
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic mask_we;
      assign mask_we    = bus_we_i && (bus_addr_i == ADDR_MASK_BASE + ADDR_W'(g));
      assign grp_clr[g] = ack_i[g] | (wr_flag & bus_wdata_i[g]);

      pcint_group #(
         .PRESENT (PIN_PRESENT[g*GRP_W +: GRP_W])
      ) u_group (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .lvl_i        (pins_sync[g*GRP_W +: GRP_W]),
         .mask_we_i    (mask_we),
         .mask_wdata_i (bus_wdata_i),
         .clr_i        (grp_clr[g]),
         .mask_o       (grp_mask[g]),
         .chg_o        (grp_chg[g]),
         .flag_o       (grp_flag[g])
      );
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_CTRL) begin
         bus_rdata_o = widen_to_byte(MAX_GRP'(en_q), NUM_GRP);
      end else if (bus_addr_i == ADDR_FLAG) begin
         bus_rdata_o = widen_to_byte(MAX_GRP'(grp_flag), NUM_GRP);
      end else begin
         for (int g = 0; g < NUM_GRP; g++) begin
            if (bus_addr_i == ADDR_MASK_BASE + ADDR_W'(g)) bus_rdata_o = grp_mask[g];
         end
      end
   end

   assign irq_o = grp_flag & en_q & {NUM_GRP{gie_i}};

endmodule

// File: rtl/pcint_ctrl_chk.sv
module pcint_ctrl_chk #(
   parameter int                NUM_GRP   = 3,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'h68,
   parameter logic [ADDR_W-1:0] ADDR_FLAG = 8'h3B
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [ADDR_W-1:0]  bus_addr_i,
   input logic [7:0]         bus_rdata_o,
   input logic [NUM_GRP-1:0] ack_i,
   input logic               gie_i,
   input logic [NUM_GRP-1:0] irq_o,
   input logic [NUM_GRP-1:0] grp_chg,
   input logic [NUM_GRP-1:0] grp_flag
);

   assert_ctrl_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == ADDR_CTRL) |-> (bus_rdata_o[7:NUM_GRP] == '0));

   assert_flag_reserved_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == ADDR_FLAG) |-> (bus_rdata_o[7:NUM_GRP] == '0));

   assert_change_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|grp_chg) |=> ((grp_flag & $past(grp_chg)) == $past(grp_chg)));

   assert_irq_needs_gie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|irq_o) |-> gie_i);

   assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(ack_i & ~grp_chg)) |=> ((grp_flag & $past(ack_i & ~grp_chg)) == '0));

   assert_change_beats_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(ack_i & grp_chg)) |=> ((grp_flag & $past(ack_i & grp_chg)) == $past(ack_i & grp_chg)));

endmodule

bind pcint_ctrl pcint_ctrl_chk #(
   .NUM_GRP   (NUM_GRP),
   .ADDR_W    (ADDR_W),
   .ADDR_CTRL (ADDR_CTRL),
   .ADDR_FLAG (ADDR_FLAG)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_addr_i  (bus_addr_i),
   .bus_rdata_o (bus_rdata_o),
   .ack_i       (ack_i),
   .gie_i       (gie_i),
   .irq_o       (irq_o),
   .grp_chg     (grp_chg),
   .grp_flag    (grp_flag)
);

// File: tb/tb_pcint_ctrl.sv
module tb_pcint_ctrl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] pins = '0;
   logic [7:0]  addr = '0;
   logic        we = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [2:0]  ack = '0;
   logic        gie = 1'b0;
   logic [2:0]  irq;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // reference model state
   logic [23:0] hist [$];
   logic [2:0]  m_en;
   logic [2:0]  m_flag;
   logic [7:0]  m_mask [3];

   always #(CLK_PERIOD/2) clk = ~clk;

   pcint_ctrl dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .pins_i      (pins),
      .bus_addr_i  (addr),
      .bus_we_i    (we),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .ack_i       (ack),
      .gie_i       (gie),
      .irq_o       (irq)
   );

   function automatic logic [7:0] model_read(input logic [7:0] a);
      if (a == 8'h68) return {5'b0, m_en};
      if (a == 8'h3B) return {5'b0, m_flag};
      if (a == 8'h6B) return m_mask[0];
      if (a == 8'h6C) return m_mask[1];
      if (a == 8'h6D) return m_mask[2];
      return 8'h00;
   endfunction

   // model update on every rising edge, from inputs driven at the falling edge
   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{24'h0, 24'h0, 24'h0};
         m_en = '0;
         m_flag = '0;
         for (int g = 0; g < 3; g++) m_mask[g] = '0;
      end else begin
         logic [2:0]  chg;
         logic [2:0]  clr;
         logic [23:0] diff;
         // hist[0]: level one cycle older than hist[1], the synchronised level
         diff = hist[1] ^ hist[0];
         for (int g = 0; g < 3; g++) chg[g] = |(diff[g*8 +: 8] & m_mask[g]);
         clr = ack | ((we && addr == 8'h3B) ? wdata[2:0] : 3'b000);
         m_flag = chg | (m_flag & ~clr);
         if (we && addr == 8'h68) m_en = wdata[2:0];
         if (we && addr == 8'h6B) m_mask[0] = wdata;
         if (we && addr == 8'h6C) m_mask[1] = wdata & 8'h7F;
         if (we && addr == 8'h6D) m_mask[2] = wdata;
         hist.push_back(pins);
         void'(hist.pop_front());
      end
   end

   // compare a quarter period after each rising edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (!done) begin
         logic [7:0] exp_rd;
         logic [2:0] exp_irq;
         exp_rd  = model_read(addr);
         exp_irq = m_flag & m_en & {3{gie}};
         n_checks++;
         if (rdata !== exp_rd) begin
            n_errors++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", cur_req, addr, rdata, exp_rd);
         end
         n_checks++;
         if (irq !== exp_irq) begin
            n_errors++;
            $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, exp_irq);
         end
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      addr = a; wdata = d; we = 1'b1;
      tick(1);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a);
      addr = a;
      tick(1);
   endtask

   // explicit expectation on top of the per-cycle comparison
   task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string req);
      addr = a;
      #1;
      n_checks++;
      if (rdata !== e) begin
         n_errors++;
         $display("FAIL %s read %h actual=%h expected=%h", req, a, rdata, e);
      end
   endtask

   task automatic summary();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      summary();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1: every register reads zero after reset
      cur_req = "R1";
      expect_rd(8'h68, 8'h00, "R1");
      expect_rd(8'h3B, 8'h00, "R1");
      expect_rd(8'h6B, 8'h00, "R1");
      expect_rd(8'h6C, 8'h00, "R1");
      expect_rd(8'h6D, 8'h00, "R1");
      tick(1);

      // R2: reserved control bits
      cur_req = "R2";
      wr(8'h68, 8'hFF);
      expect_rd(8'h68, 8'h07, "R2");
      tick(1);
      wr(8'h68, 8'hF8);
      expect_rd(8'h68, 8'h00, "R2");
      tick(1);

      // R3: unmapped addresses read zero
      cur_req = "R3";
      wr(8'h50, 8'hFF);
      expect_rd(8'h50, 8'h00, "R3");
      tick(1);

      // R4: mask registers and the reserved bit of group 1
      cur_req = "R4";
      wr(8'h6B, 8'hFF);
      wr(8'h6C, 8'hFF);
      wr(8'h6D, 8'hFF);
      expect_rd(8'h6C, 8'h7F, "R4");
      expect_rd(8'h6B, 8'hFF, "R4");
      tick(1);
      pins[15] = 1'b1;
      tick(5);
      expect_rd(8'h3B, 8'h00, "R4");
      pins[15] = 1'b0;
      tick(5);
      expect_rd(8'h3B, 8'h00, "R4");

      // R5 and R7: rising edge sets flag with group disabled; exact latency
      cur_req = "R5";
      pins[3] = 1'b1;
      tick(2);
      expect_rd(8'h3B, 8'h00, "R5");
      tick(1);
      expect_rd(8'h3B, 8'h01, "R5");
      cur_req = "R7";
      expect_rd(8'h68, 8'h00, "R7");
      tick(1);

      // R5: falling edge on group 2, rising on group 1
      cur_req = "R5";
      pins[20] = 1'b1;
      tick(4);
      wr(8'h3B, 8'h05);
      expect_rd(8'h3B, 8'h00, "R10");
      pins[20] = 1'b0;
      tick(4);
      expect_rd(8'h3B, 8'h04, "R5");
      pins[9] = 1'b1;
      tick(4);
      expect_rd(8'h3B, 8'h06, "R5");

      // R10: write zero keeps, write one clears
      cur_req = "R10";
      wr(8'h3B, 8'h00);
      expect_rd(8'h3B, 8'h06, "R10");
      tick(1);
      wr(8'h3B, 8'h02);
      expect_rd(8'h3B, 8'h04, "R10");
      tick(1);

      // R8: request gating
      cur_req = "R8";
      pins[0] = 1'b1;
      tick(4);
      wr(8'h68, 8'h05);
      tick(2);
      gie = 1'b1;
      tick(2);
      wr(8'h68, 8'h01);
      tick(2);
      gie = 1'b0;
      tick(2);
      gie = 1'b1;
      wr(8'h68, 8'h07);
      tick(2);

      // R9: acknowledge clears one group
      cur_req = "R9";
      ack = 3'b001;
      tick(1);
      ack = 3'b000;
      expect_rd(8'h3B, 8'h04, "R9");
      ack = 3'b100;
      tick(1);
      ack = 3'b000;
      expect_rd(8'h3B, 8'h00, "R9");
      tick(2);

      // R6: masked pin does nothing
      cur_req = "R6";
      wr(8'h6B, 8'hF7);
      pins[3] = 1'b0;
      tick(5);
      expect_rd(8'h3B, 8'h00, "R6");
      wr(8'h6D, 8'h00);
      pins[23:16] = 8'hA5;
      tick(5);
      expect_rd(8'h3B, 8'h00, "R6");
      tick(1);

      // R11: change and acknowledge in the same cycle
      cur_req = "R11";
      pins[9] = 1'b0;
      tick(2);
      ack = 3'b010;
      tick(1);
      ack = 3'b000;
      expect_rd(8'h3B, 8'h02, "R11");
      tick(2);
      // change and write-one clear in the same cycle
      wr(8'h3B, 8'h02);
      pins[10] = 1'b1;
      tick(2);
      wr(8'h3B, 8'h02);
      expect_rd(8'h3B, 8'h02, "R11");
      tick(3);

      summary();
   end

endmodule